// File: doc/BRIEF.md
# GPIO controller with per-pin interrupts

This block is a word-addressed general-purpose I/O controller for up to 32 pads. Software reaches it through a simple register bus with separate read and write strobes, a byte address, write data and read data. Each pad has its own register bits for sensing, driving, drive enable and polarity inversion. Bit n of every register belongs to pad n.

Each sensed pad can flag four kinds of event: a rising edge, a falling edge, a high level and a low level. Every kind has its own enable register and its own sticky pending register. The pending registers are cleared by writing ones. Each pad drives one interrupt line. That line is high while any of its four event kinds is both pending and enabled. Pad inputs are resynchronised through two flops before they are read or classified.

The register offsets are part of the behaviour because software decodes them. The enable and pending registers of the four kinds alternate, starting at byte 0x18.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: Register byte offsets are: sensed level 0x00, sense enable 0x04, drive enable 0x08, drive value 0x0C, rise enable 0x18, rise pending 0x1C, fall enable 0x20, fall pending 0x24, high enable 0x28, high pending 0x2C, low enable 0x30, low pending 0x34, invert 0x40. Read data is combinational while `bus_rd` is high. It is zero while `bus_rd` is low. It is zero for any other address, including addresses that are not word aligned.
- R2: After reset every register is zero, and `pin_irq`, `pad_oe` and `pad_out` are zero.
- R3: `pad_out` equals drive value XOR invert, and `pad_oe` equals the drive enable register.
- R4: Reading the drive value register returns the value last written to it, not the pad level.
- R5: The sensed-level register returns each pad level after two clock edges of synchronisation, forced to zero where sense enable is clear.
- R6: A 0-to-1 change of a sensed pad sets its rise pending bit one edge after the synchronised level changes, whether or not rise enable is set.
- R7: A 1-to-0 change of a sensed pad sets its fall pending bit in the same way.
- R8: A sensed pad sets its high (low) pending bit on every cycle it is high (low). Clearing the bit has a lasting effect only once that level has gone.
- R9: Writing a 1 to a bit of a pending register clears that bit. Writing 0 leaves the bit unchanged, and other bits are not affected.
- R10: When an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R11: `pin_irq[n]` is the OR over the four kinds of (pending AND enable) for pad n.
- R12: A pad whose sense enable is clear produces no edge or level events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pad_in | input | NPIN | Pad levels (asynchronous) |
| pad_out | output | NPIN | Pad drive value |
| pad_oe | output | NPIN | Pad drive enable |
| pin_irq | output | NPIN | Per-pad interrupt lines |

## Verification
A pending bit can be set by a detected edge in the same cycle that a software write clears it. The bench provokes this by raising a sensed pad and counting the synchronizer edges, so that the write-one-to-clear to the rise pending register lands exactly in the cycle of the edge event. It then judges that the bit reads back set. A second clearing write one cycle later must leave it clear. The same collision occurs every cycle for level events, and the bench judges it by clearing the low pending register while some pads stay low: the bits of the pads that are still low read back set, and the others read back clear.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned N_KIND = 4;

    // word indices (byte offset / 4)
    localparam logic [5:0] W_LEVEL   = 6'h00;
    localparam logic [5:0] W_SENSE   = 6'h01;
    localparam logic [5:0] W_DRV_EN  = 6'h02;
    localparam logic [5:0] W_DRV_VAL = 6'h03;
    localparam logic [5:0] W_KIND_LO = 6'h06;  // first enable word of the kind block
    localparam logic [5:0] W_KIND_HI = 6'h0D;  // last pending word of the kind block
    localparam logic [5:0] W_INVERT  = 6'h10;

    typedef enum logic [1:0] {
        KIND_RISE = 2'd0,
        KIND_FALL = 2'd1,
        KIND_HIGH = 2'd2,
        KIND_LOW  = 2'd3
    } irq_kind_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_SENSE,
        SEL_DRV_EN,
        SEL_DRV_VAL,
        SEL_INVERT,
        SEL_KIND_EN,
        SEL_KIND_PD
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e  sel;
        irq_kind_e kind;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t   d;
        logic [5:0] w;
        logic [5:0] rel;
        w      = a[ADDR_W-1:2];
        rel    = w - W_KIND_LO;
        d.sel  = SEL_NONE;
        d.kind = irq_kind_e'(rel[2:1]);
        if (a[1:0] == 2'b00) begin
            if (w == W_LEVEL)        d.sel = SEL_LEVEL;
            else if (w == W_SENSE)   d.sel = SEL_SENSE;
            else if (w == W_DRV_EN)  d.sel = SEL_DRV_EN;
            else if (w == W_DRV_VAL) d.sel = SEL_DRV_VAL;
            else if (w == W_INVERT)  d.sel = SEL_INVERT;
            else if (w >= W_KIND_LO && w <= W_KIND_HI)
                d.sel = rel[0] ? SEL_KIND_PD : SEL_KIND_EN;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPIN-1:0]               level,
    input  logic [NPIN-1:0]               sense_en,
    output logic [N_KIND-1:0][NPIN-1:0]   event_o
);
    logic [NPIN-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    always_comb begin
        event_o            = '0;
        event_o[KIND_RISE] = sense_en &  level & ~prev_q;
        event_o[KIND_FALL] = sense_en & ~level &  prev_q;
        event_o[KIND_HIGH] = sense_en &  level;
        event_o[KIND_LOW]  = sense_en & ~level;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_KIND-1:0][NPIN-1:0]   event_i,
    input  logic [N_KIND-1:0]             en_wr,
    input  logic [N_KIND-1:0]             pd_wr,
    input  logic [NPIN-1:0]               wdata,
    output logic [N_KIND-1:0][NPIN-1:0]   en_q,
    output logic [N_KIND-1:0][NPIN-1:0]   pend_q,
    output logic [NPIN-1:0]               irq
);
    genvar k;
    generate
        for (k = 0; k < N_KIND; k++) begin : g_kind
            logic [NPIN-1:0] clr_mask;
            assign clr_mask = pd_wr[k] ? wdata : '0;

            always_ff @(posedge clk) begin
                if (!rst_n)        en_q[k] <= '0;
                else if (en_wr[k]) en_q[k] <= wdata;
            end

            // a set in the same cycle as a clear wins
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q[k] <= '0;
                else        pend_q[k] <= (pend_q[k] & ~clr_mask) | event_i[k];
            end
        end
    endgenerate

    always_comb begin
        irq = '0;
        for (int i = 0; i < N_KIND; i++)
            irq = irq | (pend_q[i] & en_q[i]);
    end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pin_irq
);
    reg_dec_t                      dec;
    logic [NPIN-1:0]               wdata_p;
    logic [NPIN-1:0]               sense_q, drv_en_q, drv_val_q, invert_q;
    logic [NPIN-1:0]               sync_lvl, lvl_masked;
    logic [N_KIND-1:0][NPIN-1:0]   events;
    logic [N_KIND-1:0][NPIN-1:0]   irq_en, irq_pend;
    logic [N_KIND-1:0]             en_wr, pd_wr;
    logic [DATA_W-1:0]             rd_word;

    assign dec     = decode_addr(bus_addr);
    assign wdata_p = bus_wdata[NPIN-1:0];

    always_comb begin
        en_wr = '0;
        pd_wr = '0;
        for (int k = 0; k < N_KIND; k++) begin
            en_wr[k] = bus_wr && (dec.sel == SEL_KIND_EN) && (dec.kind == irq_kind_e'(k));
            pd_wr[k] = bus_wr && (dec.sel == SEL_KIND_PD) && (dec.kind == irq_kind_e'(k));
        end
    end

    // pad control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q   <= '0;
            drv_en_q  <= '0;
            drv_val_q <= '0;
            invert_q  <= '0;
        end else if (bus_wr) begin
            unique case (dec.sel)
                SEL_SENSE:   sense_q   <= wdata_p;
                SEL_DRV_EN:  drv_en_q  <= wdata_p;
                SEL_DRV_VAL: drv_val_q <= wdata_p;
                SEL_INVERT:  invert_q  <= wdata_p;
                default: ;
            endcase
        end
    end

    gpio_pad_sync #(.W(NPIN), .STAGES(2)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_lvl)
    );

    gpio_event_det #(.NPIN(NPIN)) det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (sync_lvl),
        .sense_en (sense_q),
        .event_o  (events)
    );

    gpio_irq_bank #(.NPIN(NPIN)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (events),
        .en_wr   (en_wr),
        .pd_wr   (pd_wr),
        .wdata   (wdata_p),
        .en_q    (irq_en),
        .pend_q  (irq_pend),
        .irq     (pin_irq)
    );

    assign lvl_masked = sync_lvl & sense_q;
    assign pad_out    = drv_val_q ^ invert_q;
    assign pad_oe     = drv_en_q;

    always_comb begin
        rd_word = '0;
        unique case (dec.sel)
            SEL_LEVEL:   rd_word = DATA_W'(lvl_masked);
            SEL_SENSE:   rd_word = DATA_W'(sense_q);
            SEL_DRV_EN:  rd_word = DATA_W'(drv_en_q);
            SEL_DRV_VAL: rd_word = DATA_W'(drv_val_q);
            SEL_INVERT:  rd_word = DATA_W'(invert_q);
            SEL_KIND_EN: rd_word = DATA_W'(irq_en[dec.kind]);
            SEL_KIND_PD: rd_word = DATA_W'(irq_pend[dec.kind]);
            SEL_NONE:    rd_word = '0;
            default:     rd_word = '0;
        endcase
        bus_rdata = bus_rd ? rd_word : '0;
    end
endmodule

// File: rtl/gpio_pin_chk.sv
module gpio_pin_chk
    import gpio_pin_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_rd,
    input logic                          bus_wr,
    input logic [7:0]                    bus_addr,
    input logic [31:0]                   bus_rdata,
    input logic [NPIN-1:0]               pin_irq,
    input logic [NPIN-1:0]               sense_q,
    input logic [N_KIND-1:0][NPIN-1:0]   en_q,
    input logic [N_KIND-1:0][NPIN-1:0]   pend_q
);
    logic [5:0]      word;
    logic            pd_write;
    logic [NPIN-1:0] any_en, any_pend;

    assign word     = bus_addr[7:2];
    assign pd_write = bus_wr && (bus_addr[1:0] == 2'b00) && word[0]
                      && (word >= 6'h07) && (word <= 6'h0D);
    assign any_en   = en_q[0] | en_q[1] | en_q[2] | en_q[3];
    assign any_pend = pend_q[0] | pend_q[1] | pend_q[2] | pend_q[3];

    assert_enables_clear_R2: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0));

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_irq & ~any_en) == '0));

    assert_irq_needs_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_irq & ~any_pend) == '0));

    assert_pending_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_write |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    assert_idle_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    assert_level_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h00) |-> ((bus_rdata & ~32'(sense_q)) == '0));
endmodule

bind gpio_pin_ctrl gpio_pin_chk #(.NPIN(NPIN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_irq   (pin_irq),
    .sense_q   (sense_q),
    .en_q      (irq_en),
    .pend_q    (irq_pend)
);

// File: tb/gpio_pin_ctrl_tb.sv
module gpio_pin_ctrl_tb_top;
    localparam int NPIN = 32;
    localparam logic [7:0] A_LEVEL = 8'h00, A_SENSE = 8'h04, A_DEN = 8'h08, A_DVAL = 8'h0C,
                           A_REN = 8'h18, A_RPD = 8'h1C, A_FEN = 8'h20, A_FPD = 8'h24,
                           A_HEN = 8'h28, A_HPD = 8'h2C, A_LEN = 8'h30, A_LPD = 8'h34,
                           A_INV = 8'h40;

    // {drive value, invert, drive enable, expected pad_out}
    localparam logic [31:0] VEC [5][4] = '{
        '{32'h0000FFFF, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF},
        '{32'h0000FFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hFFFF0000},
        '{32'hDEADBEEF, 32'h00FF00FF, 32'h00000000, 32'hDE52BE10},
        '{32'h80000001, 32'h80000001, 32'h80000001, 32'h00000000},
        '{32'h00000000, 32'hAAAAAAAA, 32'h55555555, 32'hAAAAAAAA}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe, pin_irq;
    int              n_tests = 0, n_fail = 0;
    logic [31:0]     rv;

    always #5 clk = ~clk;

    gpio_pin_ctrl #(.NPIN(NPIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_irq(pin_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        check("R2 pin_irq", pin_irq, 0);
        check("R2 pad_oe", pad_oe, 0);
        check("R2 pad_out", pad_out, 0);
        rd(A_REN, rv); check("R2 rise enable", rv, 0);
        rd(A_FEN, rv); check("R2 fall enable", rv, 0);
        rd(A_HEN, rv); check("R2 high enable", rv, 0);
        rd(A_LEN, rv); check("R2 low enable", rv, 0);

        // R3: drive path table
        for (int i = 0; i < 5; i++) begin
            wr(A_DVAL, VEC[i][0]);
            wr(A_INV, VEC[i][1]);
            wr(A_DEN, VEC[i][2]);
            check("R3 pad_out", pad_out, VEC[i][3]);
            check("R3 pad_oe", pad_oe, VEC[i][2]);
        end

        // R4: drive value readback is the written value, not the pad
        wr(A_DVAL, 32'h12345678);
        wr(A_INV, 32'hFFFFFFFF);
        rd(A_DVAL, rv); check("R4 drive readback", rv, 32'h12345678);
        check("R4 pad_out inverted", pad_out, 32'hEDCBA987);
        rd(A_INV, rv); check("R1 invert readback", rv, 32'hFFFFFFFF);
        rd(8'h10, rv); check("R1 unmapped read", rv, 0);
        rd(8'h0D, rv); check("R1 misaligned read", rv, 0);
        wr(A_INV, 0); wr(A_DEN, 0); wr(A_DVAL, 0);

        // R5/R6/R8: sense pads 0..7, then raise a pattern
        wr(A_SENSE, 32'h000000FF);
        pad_in = 32'hA5A5A5A5;
        repeat (4) @(negedge clk);
        rd(A_LEVEL, rv); check("R5 sensed level masked", rv, 32'h000000A5);
        rd(A_RPD, rv); check("R6 rise pending without enable", rv, 32'h000000A5);
        rd(A_FPD, rv); check("R7 no fall yet", rv, 0);
        rd(A_HPD, rv); check("R8 high pending", rv, 32'h000000A5);
        rd(A_LPD, rv); check("R8 low pending sticky", rv, 32'h000000FF);
        check("R11 no irq without enables", pin_irq, 0);
        wr(A_LPD, 32'hFFFFFFFF);
        rd(A_LPD, rv); check("R8 low re-set while level holds", rv, 32'h0000005A);

        // R9: write-one-to-clear semantics
        wr(A_RPD, 32'h0);
        rd(A_RPD, rv); check("R9 write 0 no effect", rv, 32'h000000A5);
        wr(A_RPD, 32'h1);
        rd(A_RPD, rv); check("R9 per-bit clear", rv, 32'h000000A4);
        wr(A_RPD, 32'hFF);
        rd(A_RPD, rv); check("R9 clear all", rv, 0);

        // R11: enable gating
        wr(A_HEN, 32'h1);
        check("R11 high irq pin0", pin_irq, 32'h1);
        wr(A_REN, 32'h4);
        check("R11 rise enable without pending", pin_irq, 32'h1);
        wr(A_HEN, 32'h0);
        check("R11 irq drops with enable", pin_irq, 0);

        // R7: falling edges on pins 0,2,5,7
        pad_in = 32'hA5A5A500;
        repeat (4) @(negedge clk);
        rd(A_FPD, rv); check("R7 fall pending", rv, 32'h000000A5);
        check("R11 no irq from disabled kinds", pin_irq, 0);
        wr(A_FEN, 32'h4);
        check("R11 fall irq pin2", pin_irq, 32'h4);
        wr(A_FPD, 32'h4);
        check("R9 clear drops irq", pin_irq, 0);
        wr(A_FEN, 0); wr(A_REN, 0);
        wr(A_HPD, 32'hFF);
        rd(A_HPD, rv); check("R8 high clear lasts once level gone", rv, 0);

        // R12: pad 8 is high but not sensed
        rd(A_RPD, rv); check("R12 no rise on unsensed pad", rv, 0);
        rd(A_HPD, rv); check("R12 no high on unsensed pad", rv, 0);
        rd(A_LEVEL, rv); check("R12 level masked for unsensed pad", rv, 0);

        // R10: clear lands in the same cycle as the rise event
        @(negedge clk);
        pad_in[0] = 1'b1;
        @(negedge clk);            // first sync edge passed
        @(negedge clk);            // second sync edge passed: event visible now
        bus_wr = 1'b1; bus_addr = A_RPD; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_RPD, rv); check("R10 set wins over clear", rv, 32'h1);
        wr(A_RPD, 32'h1);
        rd(A_RPD, rv); check("R9 later clear takes effect", rv, 0);

        @(negedge clk);
        check("R1 idle read data", bus_rdata, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule